// File: doc/BRIEF.md
# Burst Ramp Envelope Shaper

This block multiplies a pair of signed I/Q sample streams by an amplitude envelope. Each transmit burst starts from silence, rises smoothly to full scale and later falls back to silence. A rise or fall always begins on a symbol boundary. Each one lasts two symbol periods and follows a raised-cosine curve.

The curve is held as 32 steps, 16 per symbol, in a built-in gain table. The table stores one quarter of a cosine period and the rest is mirrored from it. The envelope moves one step on each sample strobe. A ramp command is only a request: `up_req` is taken in the silent state, `down_req` while rising or at full scale, and either one acts on the next `sym_tick`. When a fall is requested during a rise, it begins at the level already reached. Outside a burst the scaled outputs are exactly zero, whatever the input data.

The outputs are registered and are updated only on a sample strobe. `active` marks that the gain behind the held output sample is nonzero, so it can gate a power amplifier.

Top module: `burst_envelope_shaper`

## Requirements
- R1: During and right after reset, `i_out` and `q_out` are 0 and `active` is low.
- R2: A pulse on `up_req` in the silent state has no effect until the next sample strobe that comes with `sym_tick`. Until then every output sample is 0.
- R3: The rise starts at the strobed sample that carries `sym_tick`, counted as n=0. For n=0..31 the gain is g=floor(1023·(1−cos(πn/32))/2+0.5), so the rise lasts two 16-sample symbols.
- R4: Each output sample is floor((x·g+512)/1024), where x is the signed input and g the unsigned 10-bit gain. From rise sample 32 onward g=1023, so every input passes unchanged except −512, which gives −511.
- R5: A `down_req` taken at full scale starts the fall at the next strobed `sym_tick` sample, counted as n=0. For n=0..31 the gain is floor(1023·(1+cos(πn/32))/2+0.5).
- R6: Once a fall has ended, every output sample is 0 and `active` stays low until a new rise starts.
- R7: `active` is high exactly when the gain used for the currently held output sample is nonzero. Whenever `active` is low, both outputs are 0.
- R8: With `smp_en` low, `i_out`, `q_out` and `active` keep their values.
- R9: A `down_req` during a rise that has produced m samples (last gain step m−1) makes the following boundary sample use step m−1 again. The samples after it use m−2, …, 0.
- R10: `down_req` in the silent state and `up_req` during a fall are ignored, so the output stays as if they had not occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe: input valid, output updates, envelope steps |
| sym_tick | input | 1 | Symbol boundary marker |
| up_req | input | 1 | Request to start a burst rise |
| down_req | input | 1 | Request to start a burst fall |
| i_in | input | DW | Signed in-phase sample |
| q_in | input | DW | Signed quadrature sample |
| i_out | output | DW | Scaled in-phase sample |
| q_out | output | DW | Scaled quadrature sample |
| active | output | 1 | Gain of held output sample is nonzero |

## Verification
The bench builds the block with DW=10, the width the 10-bit gain table and the rounding are defined for. This setting brings the extreme inputs 511 and −512 within reach. With these inputs the rounding corner at unity gain shows, and so does the exact half-step at the middle of each ramp, where g is 512. Sixteen strobes per symbol put both a full two-symbol ramp and an abort at half height within a few hundred cycles. This lets the bench compare every one of the 32 rise and fall steps against the cosine formula.

// File: rtl/burst_envelope_shaper.sv
module burst_envelope_shaper #(
  parameter int DW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_en,
  input  logic                 sym_tick,
  input  logic                 up_req,
  input  logic                 down_req,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] q_in,
  output logic signed [DW-1:0] i_out,
  output logic signed [DW-1:0] q_out,
  output logic                 active
);
  localparam int GW   = 10;
  localparam int HALF = 16;
  localparam int LAST = 2 * HALF;
  localparam int KW   = $clog2(LAST + 1);
  localparam int PW   = DW + GW + 1;
  localparam logic [GW-1:0] GMAX = '1;

  typedef enum logic [1:0] {IDLE, RISE, FULL, FALL} st_t;

  st_t            st, st_eff, st_n;
  logic [KW-1:0]  k, k_base, k_n;
  logic           pend_up, pend_dn;
  logic           go_up, go_dn, abort;
  logic [GW-1:0]  gain, env_q;

  function automatic logic [GW-1:0] quarter(input int m);
    case (m)
      0:  return 10'd0;
      1:  return 10'd2;
      2:  return 10'd10;
      3:  return 10'd22;
      4:  return 10'd39;
      5:  return 10'd60;
      6:  return 10'd86;
      7:  return 10'd116;
      8:  return 10'd150;
      9:  return 10'd187;
      10: return 10'd227;
      11: return 10'd270;
      12: return 10'd316;
      13: return 10'd363;
      14: return 10'd412;
      15: return 10'd461;
      16: return 10'd512;
      default: return 10'd0;
    endcase
  endfunction

  function automatic logic [GW-1:0] env_lut(input int m);
    if (m <= HALF) return quarter(m);
    return GMAX - quarter(LAST - m);
  endfunction

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] x,
                                                 input logic [GW-1:0] g);
    logic signed [PW-1:0] p;
    p = $signed({{(GW+1){x[DW-1]}}, x}) * $signed({{DW{1'b0}}, 1'b0, g});
    p = p + $signed(PW'(1 << (GW - 1)));
    return p[GW+DW-1:GW];
  endfunction

  assign go_up  = sym_tick && pend_up && (st == IDLE);
  assign go_dn  = sym_tick && pend_dn && (st == RISE || st == FULL);
  assign abort  = go_dn && (st == RISE);
  assign st_eff = go_up ? RISE : (go_dn ? FALL : st);
  assign k_base = (abort && k != '0) ? k - 1'b1 : k;
  assign gain   = env_lut(int'(k_base));
  assign active = (env_q != '0);

  always_comb begin
    st_n = st_eff;
    k_n  = k_base;
    if (smp_en) begin
      case (st_eff)
        RISE: begin
          if (k_base >= KW'(LAST - 1)) begin
            k_n  = KW'(LAST);
            st_n = FULL;
          end else begin
            k_n = k_base + 1'b1;
          end
        end
        FALL: begin
          if (k_base <= KW'(1)) begin
            k_n  = '0;
            st_n = IDLE;
          end else begin
            k_n = k_base - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      k       <= '0;
      pend_up <= 1'b0;
      pend_dn <= 1'b0;
    end else begin
      st <= st_n;
      k  <= k_n;
      if (go_up)                           pend_up <= 1'b0;
      else if (up_req && st == IDLE)       pend_up <= 1'b1;
      if (go_dn)                           pend_dn <= 1'b0;
      else if (down_req && (st == RISE || st == FULL)) pend_dn <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_out <= '0;
      q_out <= '0;
      env_q <= '0;
    end else if (smp_en) begin
      i_out <= scale(i_in, gain);
      q_out <= scale(q_in, gain);
      env_q <= gain;
    end
  end

  function automatic int mag(input logic signed [DW-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  // R7
  zero_when_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (i_out == '0 && q_out == '0));

  // R8
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(i_out) && $stable(q_out) && $stable(active)));

  // R4
  no_gain_above_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> (mag(i_out) <= mag($past(i_in)) && mag(q_out) <= mag($past(q_in))));

  // R2
  start_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && !sym_tick) |=> (st == IDLE));

  // R3
  rise_nondecreasing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RISE && !sym_tick) |=> (k >= $past(k)));

  // R6
  idle_level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) |-> (k == '0));
endmodule

// File: tb/test_burst_envelope_shaper.sv
module test_burst_envelope_shaper;
  localparam int DW = 10;
  localparam int VEC [5][4] = '{
    '{ 511, -512,  511, -511},
    '{   0,    1,    0,    1},
    '{  -1,  100,   -1,  100},
    '{-100,  300, -100,  300},
    '{-300,   -2, -300,   -2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0, sym_tick = 1'b0, up_req = 1'b0, down_req = 1'b0;
  logic signed [DW-1:0] i_in = '0, q_in = '0;
  logic signed [DW-1:0] i_out, q_out;
  logic active;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_envelope_shaper #(.DW(DW)) i_burst_envelope_shaper (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sym_tick(sym_tick),
    .up_req(up_req), .down_req(down_req), .i_in(i_in), .q_in(q_in),
    .i_out(i_out), .q_out(q_out), .active(active));

  function automatic int g_rise(input int n);
    return int'($floor(1023.0 * (1.0 - $cos(3.14159265358979 * n / 32.0)) / 2.0 + 0.5 + 1e-6));
  endfunction

  function automatic int g_fall(input int n);
    return int'($floor(1023.0 * (1.0 + $cos(3.14159265358979 * n / 32.0)) / 2.0 + 0.5 + 1e-6));
  endfunction

  task automatic check(input string req, input bit ok, input int ai, input int aq, input bit aa,
                       input int ei, input int eq, input bit ea);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual i=%0d q=%0d active=%0d expected i=%0d q=%0d active=%0d",
               req, ai, aq, aa, ei, eq, ea);
    end
  endtask

  task automatic samp(input int xi, input int xq, input bit tk, input int g, input string req);
    int ei, eq;
    ei = (xi * g + 512) >>> 10;
    eq = (xq * g + 512) >>> 10;
    i_in = xi[DW-1:0];
    q_in = xq[DW-1:0];
    smp_en = 1'b1;
    sym_tick = tk;
    @(posedge clk); #2;
    smp_en = 1'b0;
    sym_tick = 1'b0;
    check(req, int'(i_out) == ei && int'(q_out) == eq && active == (g != 0),
          int'(i_out), int'(q_out), active, ei, eq, g != 0);
  endtask

  task automatic idle_pulse(input bit up, input bit dn);
    int pi, pq;
    bit pa;
    pi = int'(i_out); pq = int'(q_out); pa = active;
    up_req = up; down_req = dn;
    i_in = 10'sd77; q_in = -10'sd77;
    @(posedge clk); #2;
    up_req = 1'b0; down_req = 1'b0;
    check("R8", int'(i_out) == pi && int'(q_out) == pq && active == pa,
          int'(i_out), int'(q_out), active, pi, pq, pa);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", i_out == 0 && q_out == 0 && !active, int'(i_out), int'(q_out), active, 0, 0, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", i_out == 0 && q_out == 0 && !active, int'(i_out), int'(q_out), active, 0, 0, 0);

    // R10: fall request while silent is ignored
    idle_pulse(1'b0, 1'b1);
    for (int j = 0; j < 16; j++) samp(200, -150, j == 0, 0, "R10");

    // R2: rise waits for symbol boundary
    idle_pulse(1'b1, 1'b0);
    for (int j = 0; j < 3; j++) samp(400, 400, 1'b0, 0, "R2");

    // R3: full two-symbol rise
    for (int j = 0; j < 32; j++) begin
      samp(511 - j * 7, -512 + j * 5, (j % 16) == 0, g_rise(j), "R3");
      if (j == 20) idle_pulse(1'b0, 1'b0);
    end

    // R4: unity gain vectors
    for (int v = 0; v < 5; v++) begin
      i_in = VEC[v][0][DW-1:0];
      q_in = VEC[v][1][DW-1:0];
      smp_en = 1'b1;
      sym_tick = (v == 0);
      @(posedge clk); #2;
      smp_en = 1'b0;
      sym_tick = 1'b0;
      check("R4", int'(i_out) == VEC[v][2] && int'(q_out) == VEC[v][3] && active,
            int'(i_out), int'(q_out), active, VEC[v][2], VEC[v][3], 1'b1);
    end
    for (int j = 5; j < 16; j++) samp(j * 10 - 80, 60 - j * 9, 1'b0, 1023, "R4");

    // R5: full fall, R10: rise request during fall ignored
    idle_pulse(1'b0, 1'b1);
    for (int j = 0; j < 32; j++) begin
      samp(-511 + j * 11, 509 - j * 13, (j % 16) == 0, g_fall(j), "R5");
      if (j == 10) idle_pulse(1'b1, 1'b0);
    end
    // R6
    for (int j = 0; j < 16; j++) samp(300, -300, j == 0, 0, "R6");

    // R9: abort half way through rise
    idle_pulse(1'b1, 1'b0);
    for (int j = 0; j < 16; j++) samp(450, -450, j == 0, g_rise(j), "R3");
    idle_pulse(1'b0, 1'b1);
    for (int j = 0; j < 16; j++) samp(-333, 222, j == 0, g_rise(15 - j), "R9");
    for (int j = 0; j < 16; j++) samp(511, -512, j == 0, 0, "R6");

    // R7: re-check inactive output after stray strobes without boundary
    samp(123, -45, 1'b0, 0, "R7");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule